// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block recovers packet bytes from the two data lines of a low-speed (1.5 Mbit/s) USB link. It runs from a fast system clock. The raw D+ and D- levels pass through a two-stage synchronizer and are decoded into J, K and single-ended-zero states. The block then waits for an idle line and hunts for a J-to-K edge. It locks onto the sync field once a second K appears one bit time after that edge.

After lock it samples the line near mid-bit. The sample spacing comes from a whole-clock bit length plus a fractional accumulator, which adds a leap clock whenever the accumulator wraps. From the samples the block decodes NRZI, drops stuffed bits and assembles bytes LSB first. A single-ended zero seen at any sample closes the packet.

The consumer sees four things: a one-cycle byte strobe with its data, a start pulse, an end pulse that carries a partial-byte flag, and an overflow flag. The overflow flag rises once the packet exceeds the byte limit. PID, CRC and endpoint handling belong to later stages.

Top module: `usb_ls_rx`

## Requirements
- R1: Both lines pass through two flip-flops and then a state register. The decoded state, written as {D+, D-}, is J = 01, K = 10 and SE0 = 00. It reflects the raw pins of three clocks earlier.
- R2: A packet starts only in this order: the line is idle at J, a J-to-K edge appears, and the line is still K at the confirmation sample, BIT_INT + (BIT_INT+1)/2 clocks after the edge. `pkt_start` then pulses for one cycle. If the line is back at J at that sample, no packet starts and the hunt for the next edge resumes.
- R3: After lock, consecutive samples are BIT_INT or BIT_INT+1 clocks apart. A leap clock is added whenever a fractional accumulator, stepped by FRAC_NUM on each bit slot and wrapped at FRAC_DEN, overflows. Stuffed bits count as slots.
- R4: NRZI decoding gives 1 when the D- level is unchanged from the previous sample and 0 when it toggled. The reference for the first data bit is the final K of the sync field.
- R5: After six consecutive decoded 1s, the next bit is a stuffed bit. It is dropped and not counted as data, including when the run crosses a byte boundary.
- R6: Data bits fill bytes LSB first. Each complete byte within the limit is presented on `rx_data` with `rx_valid` high for exactly one cycle.
- R7: An SE0 at a sample ends the packet with a one-cycle `pkt_end` pulse. No byte is presented outside a packet.
- R8: If data bits of an unfinished byte are pending at the SE0, `pkt_partial` is high together with `pkt_end`, and those bits are never presented as a byte.
- R9: Bytes beyond MAX_BYTES in one packet are not presented. `rx_overflow` goes high when the first such byte completes and stays high until the next `pkt_start`, which clears it.
- R10: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_raw | input | 1 | Unsynchronized D+ line |
| dm_raw | input | 1 | Unsynchronized D- line |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte, valid with rx_valid |
| pkt_start | output | 1 | One-cycle pulse when the sync field is confirmed |
| pkt_end | output | 1 | One-cycle pulse when the end-of-packet SE0 is sampled |
| pkt_partial | output | 1 | With pkt_end: an unfinished byte was discarded |
| rx_overflow | output | 1 | Packet exceeded MAX_BYTES; held until the next packet start |

## Verification
The bench builds the receiver with BIT_INT = 5, FRAC_NUM = 1, FRAC_DEN = 3 and MAX_BYTES = 4. At 5⅓ clocks per bit, a multi-byte packet spans a few hundred clocks, yet the leap clock still falls on a varying bit of each byte. A mistake in the fractional schedule or the mid-bit offset therefore shifts samples across bit edges within one packet. With a four-byte limit, a six-byte packet reaches the overflow path and then the clearing of the flag on the following packet.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    // Line state encoded as {D+, D-}
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_HUNT,
        TM_CONFIRM,
        TM_RUN
    } timer_state_e;

    localparam int SYNC_STAGES = 2;
    localparam int STUFF_RUN   = 6;
    localparam int BYTE_W      = 8;

endpackage

// File: rtl/usbrx_line_sync.sv
module usbrx_line_sync
    import usbrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dp_raw,
    input  logic        dm_raw,
    output line_state_e state_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][1:0] pipe;
        line_state_e                 state;
        logic [1:0]                  warm;
    } ls_regs_t;

    ls_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        r_d.pipe[0] = {dp_raw, dm_raw};
        for (int i = 1; i < SYNC_STAGES; i++) begin
            r_d.pipe[i] = r_q.pipe[i-1];
        end
        r_d.state = line_state_e'(r_q.pipe[SYNC_STAGES-1]);
        if (r_q.warm != 2'd3) begin
            r_d.warm = r_q.warm + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pipe  <= {SYNC_STAGES{2'b01}};
            r_q.state <= LS_J;
            r_q.warm  <= 2'd0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;

    // R1: decoded state follows the raw pins three clocks later
    p_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.warm == 2'd3) |-> (2'(r_q.state) == $past({dp_raw, dm_raw}, 3)));

endmodule

// File: rtl/usbrx_bit_timer.sv
module usbrx_bit_timer
    import usbrx_pkg::*;
#(
    parameter int BIT_INT  = 10,
    parameter int FRAC_NUM = 2,
    parameter int FRAC_DEN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  line_state_e line_i,
    output logic        samp_stb_o,
    output line_state_e samp_state_o,
    output logic        lock_o
);

    localparam int FIRST_WAIT = BIT_INT + (BIT_INT + 1) / 2;
    localparam int CNT_W      = $clog2(FIRST_WAIT + 1);
    localparam int ACC_W      = $clog2(FRAC_DEN + FRAC_NUM + 1);
    localparam int GAP_W      = CNT_W + 1;

    typedef struct packed {
        timer_state_e      st;
        logic [CNT_W-1:0]  cnt;
        logic [ACC_W-1:0]  acc;
        logic              stb;
        line_state_e       sstate;
        logic              lock;
    } tm_regs_t;

    tm_regs_t r_q, r_d;

    logic [ACC_W-1:0] acc_sum;
    logic             leap;
    logic [ACC_W-1:0] acc_wrapped;
    logic [CNT_W-1:0] slot_reload;

    always_comb begin
        acc_sum     = r_q.acc + ACC_W'(FRAC_NUM);
        leap        = (acc_sum >= ACC_W'(FRAC_DEN));
        acc_wrapped = leap ? (acc_sum - ACC_W'(FRAC_DEN)) : acc_sum;
        slot_reload = CNT_W'(BIT_INT - 1) + CNT_W'(leap);

        r_d      = r_q;
        r_d.stb  = 1'b0;
        r_d.lock = 1'b0;

        case (r_q.st)
            TM_IDLE: begin
                if (line_i == LS_J) begin
                    r_d.st = TM_HUNT;
                end
            end
            TM_HUNT: begin
                if (line_i == LS_K) begin
                    r_d.st  = TM_CONFIRM;
                    r_d.cnt = CNT_W'(FIRST_WAIT - 1);
                    r_d.acc = '0;
                end else if (line_i != LS_J) begin
                    r_d.st = TM_IDLE;
                end
            end
            TM_CONFIRM: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (line_i == LS_K) begin
                    r_d.st   = TM_RUN;
                    r_d.lock = 1'b1;
                    r_d.acc  = acc_wrapped;
                    r_d.cnt  = slot_reload;
                end else if (line_i == LS_J) begin
                    r_d.st = TM_HUNT;
                end else begin
                    r_d.st = TM_IDLE;
                end
            end
            TM_RUN: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else begin
                    r_d.stb    = 1'b1;
                    r_d.sstate = line_i;
                    r_d.acc    = acc_wrapped;
                    r_d.cnt    = slot_reload;
                    if (line_i == LS_SE0) begin
                        r_d.st = TM_IDLE;
                    end
                end
            end
            default: r_d.st = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= TM_IDLE;
            r_q.cnt    <= '0;
            r_q.acc    <= '0;
            r_q.stb    <= 1'b0;
            r_q.sstate <= LS_J;
            r_q.lock   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign samp_stb_o   = r_q.stb;
    assign samp_state_o = r_q.sstate;
    assign lock_o       = r_q.lock;

    // Checker support: clocks since the last lock or sample strobe
    logic [GAP_W-1:0] since_q;
    logic             armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else begin
            if (r_q.stb || r_q.lock) begin
                since_q <= GAP_W'(1);
            end else if (since_q != '1) begin
                since_q <= since_q + GAP_W'(1);
            end
            if (r_q.lock) begin
                armed_q <= 1'b1;
            end
        end
    end

    // R3: sample spacing is the whole bit length or one leap clock more
    p_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && r_q.stb) |->
            (since_q == GAP_W'(BIT_INT) || since_q == GAP_W'(BIT_INT + 1)));

    // R2: lock is only declared on a confirmed second K
    p_lock_needs_k_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lock |-> $past(line_i == LS_K));

endmodule

// File: rtl/usbrx_deser.sv
module usbrx_deser
    import usbrx_pkg::*;
#(
    parameter int MAX_BYTES = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_stb_i,
    input  line_state_e       samp_state_i,
    input  logic              lock_i,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              pkt_start_o,
    output logic              pkt_end_o,
    output logic              pkt_partial_o,
    output logic              rx_overflow_o
);

    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int ONES_W    = $clog2(STUFF_RUN + 1);
    localparam int BITCNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic                active;
        logic                prev_lvl;
        logic [ONES_W-1:0]   ones;
        logic [BITCNT_W-1:0] bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic [CNT_W-1:0]    nbytes;
        logic                ovf;
        logic                valid;
        logic [BYTE_W-1:0]   data;
        logic                start;
        logic                endp;
        logic                partial;
    } ds_regs_t;

    ds_regs_t r_q, r_d;

    logic [1:0]        st_bits;
    logic              lvl;
    logic              bit_val;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        st_bits = samp_state_i;
        lvl     = st_bits[0];
        bit_val = (lvl == r_q.prev_lvl);
        shifted = {bit_val, r_q.shreg[BYTE_W-1:1]};

        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.start   = 1'b0;
        r_d.endp    = 1'b0;
        r_d.partial = 1'b0;

        if (lock_i) begin
            r_d.active   = 1'b1;
            r_d.prev_lvl = 1'b0;     // last sync bit is K (D- low)
            r_d.ones     = '0;
            r_d.bitcnt   = '0;
            r_d.shreg    = '0;
            r_d.nbytes   = '0;
            r_d.ovf      = 1'b0;
            r_d.start    = 1'b1;
        end else if (samp_stb_i && r_q.active) begin
            if (samp_state_i == LS_SE0) begin
                r_d.active  = 1'b0;
                r_d.endp    = 1'b1;
                r_d.partial = (r_q.bitcnt != '0);
            end else begin
                r_d.prev_lvl = lvl;
                if (r_q.ones == ONES_W'(STUFF_RUN)) begin
                    r_d.ones = '0;
                end else begin
                    r_d.shreg  = shifted;
                    r_d.ones   = bit_val ? (r_q.ones + ONES_W'(1)) : '0;
                    r_d.bitcnt = r_q.bitcnt + BITCNT_W'(1);
                    if (r_q.bitcnt == BITCNT_W'(BYTE_W - 1)) begin
                        r_d.bitcnt = '0;
                        if (r_q.nbytes < CNT_W'(MAX_BYTES)) begin
                            r_d.valid  = 1'b1;
                            r_d.data   = shifted;
                            r_d.nbytes = r_q.nbytes + CNT_W'(1);
                        end else begin
                            r_d.ovf = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_valid_o    = r_q.valid;
    assign rx_data_o     = r_q.data;
    assign pkt_start_o   = r_q.start;
    assign pkt_end_o     = r_q.endp;
    assign pkt_partial_o = r_q.partial;
    assign rx_overflow_o = r_q.ovf;

    // R2: start is a single-cycle pulse
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.start |=> !r_q.start);

    // R7: end only follows a sampled SE0
    p_end_on_se0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.endp |-> $past(samp_stb_i && samp_state_i == LS_SE0));

    // R6: a byte is only presented after a data sample
    p_valid_after_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> $past(samp_stb_i && samp_state_i != LS_SE0));

    // R8: partial flag only accompanies the end pulse
    p_partial_with_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.partial |-> r_q.endp);

    // R9: no byte is presented while overflow is flagged
    p_no_valid_in_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ovf |-> !r_q.valid);

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
    import usbrx_pkg::*;
#(
    parameter int BIT_INT   = 10,
    parameter int FRAC_NUM  = 2,
    parameter int FRAC_DEN  = 3,
    parameter int MAX_BYTES = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_raw,
    input  logic       dm_raw,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       pkt_start,
    output logic       pkt_end,
    output logic       pkt_partial,
    output logic       rx_overflow
);

    line_state_e line_state;
    logic        samp_stb;
    line_state_e samp_state;
    logic        lock;

    usbrx_line_sync u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .dp_raw  (dp_raw),
        .dm_raw  (dm_raw),
        .state_o (line_state)
    );

    usbrx_bit_timer #(
        .BIT_INT  (BIT_INT),
        .FRAC_NUM (FRAC_NUM),
        .FRAC_DEN (FRAC_DEN)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_state),
        .samp_stb_o   (samp_stb),
        .samp_state_o (samp_state),
        .lock_o       (lock)
    );

    usbrx_deser #(
        .MAX_BYTES (MAX_BYTES)
    ) u_deser (
        .clk           (clk),
        .rst_n         (rst_n),
        .samp_stb_i    (samp_stb),
        .samp_state_i  (samp_state),
        .lock_i        (lock),
        .rx_valid_o    (rx_valid),
        .rx_data_o     (rx_data),
        .pkt_start_o   (pkt_start),
        .pkt_end_o     (pkt_end),
        .pkt_partial_o (pkt_partial),
        .rx_overflow_o (rx_overflow)
    );

endmodule

// File: tb/usb_ls_rx_test.sv
module usb_ls_rx_test;

    localparam int T_INT = 5;
    localparam int T_NUM = 1;
    localparam int T_DEN = 3;
    localparam int T_MAX = 4;

    localparam logic [1:0] ST_J   = 2'b01;
    localparam logic [1:0] ST_K   = 2'b10;
    localparam logic [1:0] ST_SE0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp_raw = 1'b0;
    logic       dm_raw = 1'b1;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       pkt_start;
    logic       pkt_end;
    logic       pkt_partial;
    logic       rx_overflow;

    always #5 clk = ~clk;

    usb_ls_rx #(
        .BIT_INT   (T_INT),
        .FRAC_NUM  (T_NUM),
        .FRAC_DEN  (T_DEN),
        .MAX_BYTES (T_MAX)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dp_raw      (dp_raw),
        .dm_raw      (dm_raw),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .pkt_start   (pkt_start),
        .pkt_end     (pkt_end),
        .pkt_partial (pkt_partial),
        .rx_overflow (rx_overflow)
    );

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    int  starts = 0;
    int  ends = 0;
    bit  partial_seen = 0;
    bit  ovf_seen = 0;
    int  acc_b = 0;
    int  ones_b = 0;
    logic [1:0] cur = ST_J;
    logic [7:0] exp_q[$];
    logic [7:0] pkt_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Reference model of the consumer side, compared on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 byte outside expected packet", int'(rx_data), -1);
                end else begin
                    chk(rx_data == exp_q[0], "R6 byte value", int'(rx_data), int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
            end
            if (pkt_start) begin
                starts++;
                chk(!rx_overflow, "R9 overflow cleared at start", int'(rx_overflow), 0);
            end
            if (pkt_end) begin
                ends++;
                partial_seen = pkt_partial;
                ovf_seen     = rx_overflow;
            end
        end
    end

    // One bit slot on the wire with a fractional bit length
    task automatic put_bit(input logic [1:0] ls);
        int dur;
        dur = T_INT;
        acc_b += T_NUM;
        if (acc_b >= T_DEN) begin
            acc_b -= T_DEN;
            dur++;
        end
        dp_raw = ls[1];
        dm_raw = ls[0];
        repeat (dur) @(negedge clk);
    endtask

    task automatic toggle_cur();
        cur = (cur == ST_J) ? ST_K : ST_J;
    endtask

    task automatic send_data_bit(input bit b);
        if (!b) toggle_cur();
        put_bit(cur);
        ones_b = b ? ones_b + 1 : 0;
        if (ones_b == 6) begin
            toggle_cur();
            put_bit(cur);
            ones_b = 0;
        end
    endtask

    task automatic send_sync();
        acc_b = 0;
        // D- from first to last: K J K J K J K K
        put_bit(ST_K); put_bit(ST_J); put_bit(ST_K); put_bit(ST_J);
        put_bit(ST_K); put_bit(ST_J); put_bit(ST_K); put_bit(ST_K);
        cur    = ST_K;
        ones_b = 0;
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) put_bit(ST_J);
        cur = ST_J;
    endtask

    task automatic send_packet(input int extra, input string tag);
        int n;
        n = pkt_q.size();
        starts = 0; ends = 0; partial_seen = 0; ovf_seen = 0;
        exp_q.delete();
        for (int i = 0; i < n; i++) if (i < T_MAX) exp_q.push_back(pkt_q[i]);
        idle_bits(8);
        send_sync();
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++) send_data_bit(pkt_q[i][k]);
        for (int k = 0; k < extra; k++) send_data_bit(k % 2 == 0);
        put_bit(ST_SE0);
        put_bit(ST_SE0);
        idle_bits(6);
        chk(starts == 1, {"R2 start count ", tag}, starts, 1);
        chk(ends == 1, {"R7 end count ", tag}, ends, 1);
        chk(exp_q.size() == 0, {"R6 bytes missing ", tag}, exp_q.size(), 0);
        chk(partial_seen == (extra > 0), {"R8 partial flag ", tag}, int'(partial_seen), int'(extra > 0));
        chk(ovf_seen == (n > T_MAX), {"R9 overflow flag ", tag}, int'(ovf_seen), int'(n > T_MAX));
        pkt_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(!rx_valid && !pkt_start && !pkt_end, "R10 strobes low in reset", int'(rx_valid), 0);
        chk(!pkt_partial && !rx_overflow, "R10 flags low in reset", int'(rx_overflow), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!rx_valid && !pkt_start && !pkt_end && !pkt_partial && !rx_overflow,
            "R10 outputs low after reset", int'(rx_valid), 0);

        // R2: a lone K edge without a second K must not start a packet
        starts = 0; ends = 0;
        idle_bits(8);
        acc_b = 0;
        put_bit(ST_K);
        idle_bits(12);
        chk(starts == 0, "R2 false sync rejected", starts, 0);
        chk(ends == 0, "R7 no end after false sync", ends, 0);

        // R4 R6: plain bytes, mixed toggles
        pkt_q.push_back(8'hA5); pkt_q.push_back(8'h3C);
        send_packet(0, "R4 mixed");

        // R5: long runs of ones, stuffing crosses a byte boundary
        pkt_q.push_back(8'hFF); pkt_q.push_back(8'hFF); pkt_q.push_back(8'h01);
        send_packet(0, "R5 stuffing");

        // R8: pending bits at SE0 are flagged and dropped
        pkt_q.push_back(8'h7E); pkt_q.push_back(8'h80);
        send_packet(3, "R8 partial");

        // R9 R3: six bytes against a four-byte limit
        for (int i = 1; i <= 6; i++) pkt_q.push_back(8'(i * 37));
        send_packet(0, "R9 overflow");

        // R9 R4: the following packet starts clean; all-zero data toggles every bit
        pkt_q.push_back(8'h00);
        send_packet(0, "R9 after overflow");

        // R1: J/K/SE0 decode via a last packet whose tail has a stuffed bit
        pkt_q.push_back(8'hC3); pkt_q.push_back(8'hFC);
        send_packet(0, "R1 decode");

        finish_run();
    end

endmodule